// File: doc/BRIEF.md
# Multi-channel DMA interrupt aggregator

This block gathers completion and error events from 64 DMA channels and turns them into one or two level interrupt lines that a processor services over an APB slave port. Each channel owns one sticky status bit and one enable (mask) bit. An event shows up as a single-cycle pulse on that channel's line of a 64-bit event input. It sets the channel's status bit whatever the mask says. An interrupt output is raised only by a channel that has both its status bit and its mask bit set.

Software picks two behaviours at run time through a control register. The first is how status is cleared: either reading a status word clears the bits that read returned, or reads leave status alone and software writes ones to clear. The second is how channels map to outputs: either the lower half drives output 0 and the upper half drives output 1, or all channels are merged onto output 0 and output 1 is held low.

Register map (byte offsets): 0x00 mask for channels 0–31, 0x04 mask for channels 32–63, 0x08 control, 0x0C status for channels 0–31, 0x10 status for channels 32–63. In a status or mask word, channel n sits at bit n mod 32.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, both mask words, the control word and both status words read 0, and both interrupt outputs are low.
- R2: The mask words at 0x00 and 0x04 read back what was written. The control word at 0x08 keeps bit 0 (clear mode: 0 = clear on read, 1 = write one to clear) and bit 1 (routing: 0 = split, 1 = merged). Its bits 31:2 always read 0.
- R3: An event pulse on channel n sets status bit n mod 32 of word 0x0C (n < 32) or of word 0x10 (n ≥ 32). This happens whether or not the channel is masked.
- R4: In clear-on-read mode, an APB read of a status word returns its current bits and clears exactly those bits. An APB write to a status word has no effect.
- R5: In write-one-to-clear mode, reads of status leave it unchanged. Writing a status word clears the bits written as 1 and keeps the bits written as 0.
- R6: If an event arrives on a channel in the same cycle that its status bit is being cleared by a read or by a write, the bit stays set.
- R7: With routing = 0, output 0 is the OR over channels 0–31 of status AND mask, and output 1 is the same OR over channels 32–63. Each output is registered, so it follows the status by one clock.
- R8: With routing = 1, output 0 is the OR over all 64 channels of status AND mask, and output 1 is low.
- R9: A channel whose mask bit is 0 never raises an output. If its status bit is still set when it is unmasked, the output rises one clock after the mask write.
- R10: PREADY is always 1 and PSLVERR is always 0. A read of any offset outside the five registers returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 64 | One-cycle event pulse per channel |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when 1, read when 0 |
| paddr_i | input | 8 | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | APB ready, tied high |
| pslverr_o | output | 1 | APB error, tied low |
| irq0_o | output | 1 | Interrupt output 0, active high |
| irq1_o | output | 1 | Interrupt output 1, active high |

## Verification
The bench builds the block with its default parameters: 64 channels in two 32-bit words and an 8-bit address. With these values, both halves of the split routing and the merged routing can be reached, and a channel at each word edge (0, 31, 32, 63) can be driven directly. Directed cases cover the collision of an event with a clear, for both clear modes. Random sequences of mask, control and status accesses mixed with event bursts then switch the two modes while bits are pending.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam logic [7:0] OFS_MASK_LO = 8'h00;
  localparam logic [7:0] OFS_MASK_HI = 8'h04;
  localparam logic [7:0] OFS_CTRL    = 8'h08;
  localparam logic [7:0] OFS_STAT_LO = 8'h0C;
  localparam logic [7:0] OFS_STAT_HI = 8'h10;

  typedef struct packed {
    logic route_merged;  // bit 1
    logic clr_by_write;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int NUM_WORDS = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             psel_i,
  input  logic                             penable_i,
  input  logic                             pwrite_i,
  input  logic [ADDR_W-1:0]                paddr_i,
  input  logic [DATA_W-1:0]                pwdata_i,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0] stat_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0] mask_o,
  output ctrl_t                            ctrl_o,
  output logic [DATA_W-1:0]                prdata_o,
  output logic [NUM_WORDS-1:0]             stat_rd_o,
  output logic [NUM_WORDS-1:0]             stat_wr_o
);
  logic access, rd_en, wr_en;
  logic sel_mlo, sel_mhi, sel_ctl, sel_slo, sel_shi;
  logic [NUM_WORDS-1:0][DATA_W-1:0] mask_q;
  ctrl_t ctrl_q, ctrl_d;

  assign access  = psel_i & penable_i;
  assign rd_en   = access & ~pwrite_i;
  assign wr_en   = access &  pwrite_i;
  assign sel_mlo = (paddr_i == ADDR_W'(OFS_MASK_LO));
  assign sel_mhi = (paddr_i == ADDR_W'(OFS_MASK_HI));
  assign sel_ctl = (paddr_i == ADDR_W'(OFS_CTRL));
  assign sel_slo = (paddr_i == ADDR_W'(OFS_STAT_LO));
  assign sel_shi = (paddr_i == ADDR_W'(OFS_STAT_HI));

  assign stat_rd_o = {rd_en & sel_shi, rd_en & sel_slo};
  assign stat_wr_o = {wr_en & sel_shi, wr_en & sel_slo};

  always_comb begin
    ctrl_d.clr_by_write = pwdata_i[0];
    ctrl_d.route_merged = pwdata_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else begin
      if (wr_en && sel_mlo) mask_q[0] <= pwdata_i;
      if (wr_en && sel_mhi) mask_q[1] <= pwdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ctrl_q <= '0;
    else if (wr_en && sel_ctl) ctrl_q <= ctrl_d;
  end

  always_comb begin
    prdata_o = '0;
    if (sel_mlo)      prdata_o = mask_q[0];
    else if (sel_mhi) prdata_o = mask_q[1];
    else if (sel_ctl) prdata_o = DATA_W'({ctrl_q.route_merged, ctrl_q.clr_by_write});
    else if (sel_slo) prdata_o = stat_i[0];
    else if (sel_shi) prdata_o = stat_i[1];
  end

  assign mask_o = mask_q;
  assign ctrl_o = ctrl_q;

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && sel_ctl) |-> (prdata_o[DATA_W-1:2] == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !(sel_mlo || sel_mhi || sel_ctl || sel_slo || sel_shi)) |-> (prdata_o == '0)); // R10
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_by_write_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d, clr_mask;
  logic         upd_en;

  always_comb begin
    clr_mask = '0;
    if (clr_by_write_i) begin
      if (wr_i) clr_mask = wdata_i;
    end else begin
      if (rd_i) clr_mask = stat_q;
    end
    stat_d = (stat_q & ~clr_mask) | evt_i;
    upd_en = (|evt_i) | (|clr_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stat_q <= '0;
    else if (upd_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R6
  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_by_write_i && rd_i && evt_i == '0) |=> (stat_q == '0)); // R4
  AST_RD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_by_write_i && !wr_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R5
  AST_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_by_write_i && wr_i && !rd_i) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4
endmodule

// File: rtl/dma_irq_route.sv
module dma_irq_route #(
  parameter int NUM_CH = 64,
  localparam int HALF = NUM_CH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] stat_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              merged_i,
  output logic              irq0_o,
  output logic              irq1_o
);
  logic [NUM_CH-1:0] live;
  logic lo_any, hi_any, irq0_d, irq1_d, irq0_q, irq1_q;

  always_comb begin
    live   = stat_i & mask_i;
    lo_any = |live[HALF-1:0];
    hi_any = |live[NUM_CH-1:HALF];
    irq0_d = merged_i ? (lo_any | hi_any) : lo_any;
    irq1_d = merged_i ? 1'b0 : hi_any;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= irq0_d;
      irq1_q <= irq1_d;
    end
  end

  assign irq0_o = irq0_q;
  assign irq1_o = irq1_q;

  AST_IRQ1_QUIET_MERGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(merged_i) |-> !irq1_q); // R8
  AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_i) & $past(mask_i)) == '0) |-> (!irq0_q && !irq1_q)); // R9
  AST_SPLIT_LOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(merged_i) && irq0_q) |-> (($past(stat_i[HALF-1:0]) & $past(mask_i[HALF-1:0])) != '0)); // R7
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int NUM_WORDS = NUM_CH / DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic              irq0_o,
  output logic              irq1_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic [NUM_WORDS-1:0][DATA_W-1:0] stat_w, mask_w;
  logic [NUM_WORDS-1:0] stat_rd, stat_wr;
  ctrl_t ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  dma_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni(rst_n), .psel_i, .penable_i, .pwrite_i, .paddr_i, .pwdata_i,
    .stat_i(stat_w), .mask_o(mask_w), .ctrl_o(ctrl), .prdata_o,
    .stat_rd_o(stat_rd), .stat_wr_o(stat_wr)
  );

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    dma_irq_status #(.W(DATA_W)) u_stat (
      .clk_i, .rst_ni(rst_n),
      .evt_i(evt_i[g*DATA_W +: DATA_W]),
      .clr_by_write_i(ctrl.clr_by_write),
      .rd_i(stat_rd[g]), .wr_i(stat_wr[g]), .wdata_i(pwdata_i),
      .stat_o(stat_w[g])
    );
  end

  dma_irq_route #(.NUM_CH(NUM_CH)) u_route (
    .clk_i, .rst_ni(rst_n), .stat_i(stat_w), .mask_i(mask_w),
    .merged_i(ctrl.route_merged), .irq0_o, .irq1_o
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: tb/dma_irq_agg_tb_top.sv
module dma_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] evt;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready, pslverr, irq0, irq1;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [63:0] m_st, m_mask;
  logic        m_sce, m_mux;

  always #10 clk = ~clk;

  dma_irq_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq0_o(irq0), .irq1_o(irq1)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq0();
    if (m_mux) return |(m_st & m_mask);
    return |(m_st[31:0] & m_mask[31:0]);
  endfunction

  function automatic logic exp_irq1();
    if (m_mux) return 1'b0;
    return |(m_st[63:32] & m_mask[63:32]);
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_mask[31:0];
      8'h04: return m_mask[63:32];
      8'h08: return {30'd0, m_mux, m_sce};
      8'h0C: return m_st[31:0];
      8'h10: return m_st[63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [63:0] ev, output logic [31:0] rd);
    logic [63:0] clr;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; evt = '0;
    @(negedge clk);
    penable = 1; evt = ev;
    #1 rd = prdata;
    chk("R10 pready", {63'd0, pready}, 64'd1);
    chk("R10 pslverr", {63'd0, pslverr}, 64'd0);
    clr = '0;
    if (a == 8'h0C) clr[31:0]  = m_sce ? (wr ? d : 32'd0) : (wr ? 32'd0 : m_st[31:0]);
    if (a == 8'h10) clr[63:32] = m_sce ? (wr ? d : 32'd0) : (wr ? 32'd0 : m_st[63:32]);
    m_st = (m_st & ~clr) | ev;
    if (wr && a == 8'h00) m_mask[31:0]  = d;
    if (wr && a == 8'h04) m_mask[63:32] = d;
    if (wr && a == 8'h08) begin m_sce = d[0]; m_mux = d[1]; end
    @(negedge clk);
    psel = 0; penable = 0; evt = '0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    xfer(1'b1, a, d, 64'd0, r);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a);
    logic [31:0] e, r;
    e = exp_read(a);
    xfer(1'b0, a, 32'd0, 64'd0, r);
    chk(req, {32'd0, r}, {32'd0, e});
  endtask

  task automatic pulse(input logic [63:0] ev);
    @(negedge clk);
    evt = ev;
    m_st = m_st | ev;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic irq_chk(input string req);
    @(negedge clk);
    chk(req, {62'd0, irq1, irq0}, {62'd0, exp_irq1(), exp_irq0()});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5EED_1234));
    rst_n = 0; evt = '0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    m_st = '0; m_mask = '0; m_sce = 0; m_mux = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {62'd0, irq1, irq0}, 64'd0);
    rd_chk("R1 mask lo", 8'h00); rd_chk("R1 mask hi", 8'h04);
    rd_chk("R1 ctrl", 8'h08);
    rd_chk("R1 stat lo", 8'h0C); rd_chk("R1 stat hi", 8'h10);

    // R2 register readback, R10 unmapped
    wr_reg(8'h00, 32'hA5A5_0F0F); rd_chk("R2 mask lo", 8'h00);
    wr_reg(8'h04, 32'h1234_5678); rd_chk("R2 mask hi", 8'h04);
    wr_reg(8'h08, 32'hFFFF_FFFF); rd_chk("R2 ctrl", 8'h08);
    rd_chk("R10 unmapped 0x14", 8'h14);
    rd_chk("R10 unmapped 0xFC", 8'hFC);

    // R9 masked events latch but stay quiet (write-one-to-clear, split)
    wr_reg(8'h08, 32'h1);
    wr_reg(8'h00, 32'h0); wr_reg(8'h04, 32'h0);
    pulse(64'h8000_0001_8000_0001);
    irq_chk("R9 masked quiet");
    rd_chk("R3 stat lo edges", 8'h0C);
    rd_chk("R3 stat hi edges", 8'h10);
    rd_chk("R5 read keeps", 8'h0C);
    wr_reg(8'h00, 32'h8000_0000);
    irq_chk("R9 unmask raises");
    wr_reg(8'h04, 32'h0000_0001);
    irq_chk("R7 split irq1");
    // R8 merged
    wr_reg(8'h08, 32'h3);
    irq_chk("R8 merged");
    wr_reg(8'h00, 32'h0);
    irq_chk("R8 merged hi only");
    wr_reg(8'h08, 32'h1);
    irq_chk("R7 split back");
    // R5 write 0 keeps, write 1 clears
    wr_reg(8'h10, 32'h0);
    rd_chk("R5 write zero keeps", 8'h10);
    wr_reg(8'h10, 32'h8000_0000);
    rd_chk("R5 write one clears", 8'h10);
    irq_chk("R5 irq after clear");
    // R6 in write mode
    xfer(1'b1, 8'h10, 32'h0000_0001, 64'h0000_0001_0000_0000, r);
    rd_chk("R6 event beats write clear", 8'h10);
    // R4 clear-on-read
    wr_reg(8'h08, 32'h0);
    rd_chk("R4 read returns", 8'h0C);
    rd_chk("R4 read cleared", 8'h0C);
    pulse(64'h0000_0000_0000_0010);
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R4 write ignored", 8'h0C);
    pulse(64'h0000_0000_0000_0020);
    xfer(1'b0, 8'h0C, 32'd0, 64'h0000_0000_0000_0020, r);
    chk("R4 collision returned", {32'd0, r}, 64'h20);
    rd_chk("R6 event beats read clear", 8'h0C);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [31:0] d;
      logic [63:0] ev;
      op = $urandom_range(0, 6);
      d  = $urandom;
      ev = {32'($urandom), 32'($urandom)} & {32'($urandom), 32'($urandom)} & {32'($urandom), 32'($urandom)};
      case (op)
        0: wr_reg(($urandom_range(0, 1) != 0) ? 8'h04 : 8'h00, d);
        1: wr_reg(8'h08, d & 32'h3);
        2: rd_chk("R3 rnd stat lo", 8'h0C);
        3: rd_chk("R3 rnd stat hi", 8'h10);
        4: wr_reg(($urandom_range(0, 1) != 0) ? 8'h10 : 8'h0C, d);
        5: xfer(1'b0, ($urandom_range(0, 1) != 0) ? 8'h10 : 8'h0C, 32'd0, ev, r);
        default: pulse(ev);
      endcase
      irq_chk("R7 rnd irq");
    end
    rd_chk("R2 final mask lo", 8'h00);
    rd_chk("R2 final ctrl", 8'h08);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule